// File: doc/BRIEF.md
# Register Rename Map with Deferred Free Pool

This block is the renaming step of an out-of-order core. Each incoming instruction names two source registers and, optionally, one destination register in a small architected register space. The block translates both sources to physical register numbers through a map table. For a destination it takes a fresh physical register from a free pool, reports that register and the one it displaces, and points the destination entry at the new register. The physical register space is twice the size of the architected one, so writes to the same architected register no longer collide.

A displaced physical register is not handed back at once. A later pipeline stage returns it through a release request once the displacing instruction is final, and the block also counts outstanding readers of every physical register: each renamed source adds one and each read-complete notification removes one. A released register goes back into the free pool only when its reader count has drained to zero. When the pool is empty, an instruction that needs a destination is held with a stall. An instruction with no destination always proceeds.

Top module: `rrn_rename`

## Requirements
- R1: After reset architected register i maps to physical register i (0..7), and the free pool holds physical registers 8..15 in ascending order, so the first allocation returns 8.
- R2: For an instruction presented with valid, `ren_ps_o` and `ren_pt_o` show, in the same cycle, the current mappings of `ren_rs_i` and `ren_rt_i`.
- R3: An instruction that has a destination and is not stalled gets `ren_pd_o` equal to the oldest register in the free pool and `ren_old_pd_o` equal to the current mapping of `ren_rd_i`. From the next cycle on, `ren_rd_i` maps to `ren_pd_o`.
- R4: Source lookups use the mapping from before the same instruction's destination update, so a source equal to the destination reads the displaced register.
- R5: `ren_stall_o` is high exactly when valid, a destination is requested and the free pool is empty. A stalled instruction changes no mapping, pool content or reader count.
- R6: Each accepted instruction adds one pending read to the physical register behind each of its two sources, so two reads when both sources name the same register. Each asserted read-complete port removes one pending read from the register it names, and both ports may name the same register in one cycle.
- R7: A released physical register enters the free pool only after its pending-read count is zero. It enters at the end of the first cycle in which it is both released and free of readers, and it can be allocated from the following cycle.
- R8: When several released registers qualify in the same cycle, one enters the pool per cycle, lowest register number first.
- R9: An instruction without a destination (`ren_has_rd_i` low) is never stalled, takes nothing from the pool and changes no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ren_valid_i | input | 1 | Rename request present |
| ren_has_rd_i | input | 1 | Request writes a destination |
| ren_rs_i | input | 3 | First source architected register |
| ren_rt_i | input | 3 | Second source architected register |
| ren_rd_i | input | 3 | Destination architected register |
| ren_stall_o | output | 1 | Request held: no free physical register |
| ren_ps_o | output | 4 | Physical register of first source |
| ren_pt_o | output | 4 | Physical register of second source |
| ren_pd_o | output | 4 | Newly allocated destination physical register |
| ren_old_pd_o | output | 4 | Physical register displaced by the destination |
| done_valid_i | input | 2 | Read-complete strobes, one per port |
| done_preg_i | input | 8 | Physical register per port, port k in bits [4k+3:4k] |
| rel_valid_i | input | 1 | Release request for a displaced register |
| rel_preg_i | input | 4 | Physical register being released |

## Verification
The hardest situation to reach is a released register that is blocked only by readers while the pool is empty. Only that case shows that reclaim waits for the count and not for the release alone. The bench fills the pool to empty with instructions whose sources equal their destination, so every displaced register carries two pending reads. It then releases one and holds a request against the stall while the reads drain over separate cycles. It also releases two such registers in reverse numeric order and completes their last reads in the same cycle, which shows the lowest-first refill. A long random phase then mixes releases, read completions on both ports and stalls, and a behavioural model checks every cycle.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
  localparam int unsigned ARCH_REGS_DEF   = 8;
  localparam int unsigned PHYS_REGS_DEF   = 16;
  localparam int unsigned MAX_READERS_DEF = 15;
  localparam int unsigned DONE_PORTS_DEF  = 2;
endpackage

// File: rtl/rrn_map_table.sv
module rrn_map_table #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned PHYS_REGS = 16,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  input  logic [AW-1:0] ra_c_i,
  output logic [PW-1:0] rd_a_o,
  output logic [PW-1:0] rd_b_o,
  output logic [PW-1:0] rd_c_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [PW-1:0] wd_i
);
  logic [PW-1:0] map_q [ARCH_REGS];

  // reads see pre-update state of this cycle
  assign rd_a_o = map_q[ra_a_i];
  assign rd_b_o = map_q[ra_b_i];
  assign rd_c_o = map_q[ra_c_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else if (we_i) begin
      map_q[wa_i] <= wd_i;
    end
  end

  // R3
  map_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (map_q[$past(wa_i)] == $past(wd_i)));
endmodule

// File: rtl/rrn_free_pool.sv
module rrn_free_pool #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned PHYS_REGS = 16,
  localparam int unsigned PW    = $clog2(PHYS_REGS),
  localparam int unsigned DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int unsigned PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic          empty_o
);
  logic [PW-1:0]   mem_q [DEPTH];
  logic [PTRW-1:0] rd_q, wr_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [PTRW-1:0] ptr_inc(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
  endfunction

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= PW'(ARCH_REGS + i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CNTW'(DEPTH);
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= ptr_inc(wr_q);
      end
      if (pop_i) rd_q <= ptr_inc(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNTW'(1);
        2'b01:   cnt_q <= cnt_q - CNTW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q != CNTW'(DEPTH)));
  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rrn_reader_track.sv
module rrn_reader_track #(
  parameter int unsigned PHYS_REGS   = 16,
  parameter int unsigned MAX_READERS = 15,
  parameter int unsigned DONE_PORTS  = 2,
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned CW = $clog2(MAX_READERS + 1),
  localparam int unsigned SW = CW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_a_v_i,
  input  logic [PW-1:0] inc_a_p_i,
  input  logic          inc_b_v_i,
  input  logic [PW-1:0] inc_b_p_i,
  input  logic [DONE_PORTS-1:0] done_v_i,
  input  logic [PW-1:0] done_p_i [DONE_PORTS],
  input  logic          rel_v_i,
  input  logic [PW-1:0] rel_p_i,
  output logic          push_o,
  output logic [PW-1:0] push_p_o
);
  logic [CW-1:0]        cnt_q [PHYS_REGS];
  logic [PHYS_REGS-1:0] term_q, cand, pick_oh, rel_oh;

  for (genvar p = 0; p < PHYS_REGS; p++) begin : g_reg
    logic [SW-1:0] up, dn, ext;
    assign ext = {2'b00, cnt_q[p]};

    always_comb begin
      up = '0;
      dn = '0;
      if (inc_a_v_i && inc_a_p_i == PW'(p)) up = up + SW'(1);
      if (inc_b_v_i && inc_b_p_i == PW'(p)) up = up + SW'(1);
      for (int k = 0; k < DONE_PORTS; k++)
        if (done_v_i[k] && done_p_i[k] == PW'(p)) dn = dn + SW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[p] <= '0;
      else         cnt_q[p] <= CW'(ext + up - dn);
    end

    assign cand[p]   = term_q[p] && (cnt_q[p] == '0);
    assign rel_oh[p] = rel_v_i && (rel_p_i == PW'(p));

    // R6
    cnt_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext + up) >= dn);
    // R6
    cnt_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext + up - dn) <= SW'(MAX_READERS));
  end

  // lowest index wins; one reclaim per cycle
  always_comb begin
    push_o   = 1'b0;
    push_p_o = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        push_o   = 1'b1;
        push_p_o = PW'(i);
      end
    end
    pick_oh = '0;
    if (push_o) pick_oh[push_p_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) term_q <= '0;
    else         term_q <= (term_q & ~pick_oh) | rel_oh;
  end

  // R7
  release_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_v_i |-> !term_q[rel_p_i]);

  for (genvar k = 0; k < DONE_PORTS; k++) begin : g_done_chk
    // R6
    done_has_reader_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_v_i[k] |-> (cnt_q[done_p_i[k]] != '0));
  end
endmodule

// File: rtl/rrn_rename.sv
module rrn_rename
  import rrn_pkg::*;
#(
  parameter int unsigned ARCH_REGS   = ARCH_REGS_DEF,
  parameter int unsigned PHYS_REGS   = PHYS_REGS_DEF,
  parameter int unsigned MAX_READERS = MAX_READERS_DEF,
  parameter int unsigned DONE_PORTS  = DONE_PORTS_DEF,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ren_valid_i,
  input  logic                     ren_has_rd_i,
  input  logic [AW-1:0]            ren_rs_i,
  input  logic [AW-1:0]            ren_rt_i,
  input  logic [AW-1:0]            ren_rd_i,
  output logic                     ren_stall_o,
  output logic [PW-1:0]            ren_ps_o,
  output logic [PW-1:0]            ren_pt_o,
  output logic [PW-1:0]            ren_pd_o,
  output logic [PW-1:0]            ren_old_pd_o,
  input  logic [DONE_PORTS-1:0]    done_valid_i,
  input  logic [DONE_PORTS*PW-1:0] done_preg_i,
  input  logic                     rel_valid_i,
  input  logic [PW-1:0]            rel_preg_i
);
  logic          pool_empty, fire, alloc, push;
  logic [PW-1:0] push_p;
  logic [PW-1:0] done_p [DONE_PORTS];

  for (genvar k = 0; k < DONE_PORTS; k++) begin : g_done
    assign done_p[k] = done_preg_i[k*PW +: PW];
  end

  assign ren_stall_o = ren_valid_i && ren_has_rd_i && pool_empty;
  assign fire        = ren_valid_i && !ren_stall_o;
  assign alloc       = fire && ren_has_rd_i;

  rrn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (ren_rs_i),
    .ra_b_i (ren_rt_i),
    .ra_c_i (ren_rd_i),
    .rd_a_o (ren_ps_o),
    .rd_b_o (ren_pt_o),
    .rd_c_o (ren_old_pd_o),
    .we_i   (alloc),
    .wa_i   (ren_rd_i),
    .wd_i   (ren_pd_o)
  );

  rrn_free_pool #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_p),
    .pop_i       (alloc),
    .head_o      (ren_pd_o),
    .empty_o     (pool_empty)
  );

  rrn_reader_track #(
    .PHYS_REGS(PHYS_REGS), .MAX_READERS(MAX_READERS), .DONE_PORTS(DONE_PORTS)
  ) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_a_v_i (fire),
    .inc_a_p_i (ren_ps_o),
    .inc_b_v_i (fire),
    .inc_b_p_i (ren_pt_o),
    .done_v_i  (done_valid_i),
    .done_p_i  (done_p),
    .rel_v_i   (rel_valid_i),
    .rel_p_i   (rel_preg_i),
    .push_o    (push),
    .push_p_o  (push_p)
  );

  // R3
  pd_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |-> (ren_pd_o != ren_old_pd_o));
  // R9
  no_rd_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && !ren_has_rd_i) |-> !ren_stall_o);
endmodule

// File: tb/rrn_rename_tb.sv
module rrn_rename_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int PW = 4;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic v, hr, stall, rv;
  logic [AW-1:0] rs, rt, rd;
  logic [PW-1:0] ps, pt, pd, opd, rp;
  logic [1:0] dv;
  logic [2*PW-1:0] dp;

  int tests = 0, fails = 0;
  int map_m [NA];
  int cnt_m [NP];
  bit term_m [NP];
  int free_q [$];
  int retire_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rrn_rename u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ren_valid_i(v), .ren_has_rd_i(hr),
    .ren_rs_i(rs), .ren_rt_i(rt), .ren_rd_i(rd), .ren_stall_o(stall),
    .ren_ps_o(ps), .ren_pt_o(pt), .ren_pd_o(pd), .ren_old_pd_o(opd),
    .done_valid_i(dv), .done_preg_i(dp), .rel_valid_i(rv), .rel_preg_i(rp)
  );

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit iv, bit ihr, int irs, int irt, int ird,
                      bit d0v, int d0p, bit d1v, int d1p, bit irv, int irp);
    bit exp_stall, fire;
    int cand;
    @(negedge clk);
    v = iv; hr = ihr; rs = AW'(irs); rt = AW'(irt); rd = AW'(ird);
    dv = {d1v, d0v}; dp = {PW'(d1p), PW'(d0p)};
    rv = irv; rp = PW'(irp);
    #1;
    exp_stall = iv && ihr && (free_q.size() == 0);
    chk(tag, "stall", int'(stall), int'(exp_stall));
    if (iv) begin
      chk(tag, "ps", int'(ps), map_m[irs]);
      chk(tag, "pt", int'(pt), map_m[irt]);
    end
    if (iv && ihr && !exp_stall) begin
      chk(tag, "pd", int'(pd), free_q[0]);
      chk(tag, "old_pd", int'(opd), map_m[ird]);
    end
    cand = -1;
    for (int i = NP - 1; i >= 0; i--) if (term_m[i] && cnt_m[i] == 0) cand = i;
    fire = iv && !exp_stall;
    @(posedge clk);
    if (fire) begin
      cnt_m[map_m[irs]]++;
      cnt_m[map_m[irt]]++;
      if (ihr) begin
        int n;
        n = free_q.pop_front();
        retire_q.push_back(map_m[ird]);
        map_m[ird] = n;
      end
    end
    if (d0v) cnt_m[d0p]--;
    if (d1v) cnt_m[d1p]--;
    if (irv) term_m[irp] = 1'b1;
    if (cand >= 0) begin
      term_m[cand] = 1'b0;
      free_q.push_back(cand);
    end
  endtask

  function automatic int pick_reader(int avoid);
    int s;
    s = int'($urandom % NP);
    for (int k = 0; k < NP; k++)
      if (cnt_m[(s + k) % NP] > 0 && (s + k) % NP != avoid) return (s + k) % NP;
    return -1;
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer", WD_CYCLES);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int x, y, z, busy;
    v = 0; hr = 0; rs = '0; rt = '0; rd = '0; dv = '0; dp = '0; rv = 0; rp = '0;
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) begin cnt_m[i] = 0; term_m[i] = 0; end
    for (int i = NA; i < NP; i++) free_q.push_back(i);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset identity map, seen through source lookups (no destination)
    for (int i = 0; i < NA; i++) step("R1", 1, 0, i, (i + 1) % NA, 0, 0, 0, 0, 0, 0, 0);
    // R6 drain readers through both ports
    for (int g = 0; g < 40; g++) begin
      x = pick_reader(-1);
      if (x < 0) break;
      y = (cnt_m[x] >= 2) ? x : pick_reader(x);
      step("R6", 0, 0, 0, 0, 0, 1, x, y >= 0, (y >= 0) ? y : 0, 0, 0);
    end
    // R1 first allocation returns 8; R4 source equals destination
    step("R1", 1, 1, 2, 2, 2, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < NA; i++)
      if (i != 2) step("R4", 1, 1, i, i, i, 0, 0, 0, 0, 0, 0);
    // R5 pool empty: stall holds, R9 no-destination still passes
    step("R5", 1, 1, 3, 4, 5, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 0, 3, 4, 5, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 3, 4, 5, 0, 0, 0, 0, 0, 0);
    // R7 release a register that still has two readers
    x = retire_q.pop_front();
    step("R7", 1, 1, 0, 0, 5, 0, 0, 0, 0, 1, x);
    step("R7", 1, 1, 0, 0, 5, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 0, 5, 1, x, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 0, 5, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 0, 5, 1, x, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 0, 5, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 0, 5, 0, 0, 0, 0, 0, 0);
    // R8 release in reverse numeric order, both drain in the same cycle
    y = retire_q.pop_front();
    z = retire_q.pop_front();
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, z);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, y);
    while (cnt_m[y] > 0 || cnt_m[z] > 0)
      step("R8", 0, 0, 0, 0, 0, cnt_m[y] > 0, y, cnt_m[z] > 0, z, 0, 0);
    for (int i = 0; i < 4; i++) step("R8", 1, 1, 6, 7, 6 + (i % 2), 0, 0, 0, 0, 0, 0);

    // R2 R3 R6 R7 random traffic
    for (int c = 0; c < 4000; c++) begin
      bit iv, ihr, d0v, d1v, irv;
      int irs, irt, ird, d0p, d1p, irp;
      irs = int'($urandom % NA); irt = int'($urandom % NA); ird = int'($urandom % NA);
      iv = ($urandom % 10) < 7;
      ihr = ($urandom % 4) != 0;
      if (cnt_m[map_m[irs]] > 12 || cnt_m[map_m[irt]] > 12) iv = 0;
      d0p = 0; d1p = 0; d0v = 0; d1v = 0;
      if (($urandom % 4) != 0) begin
        busy = pick_reader(-1);
        if (busy >= 0) begin d0v = 1; d0p = busy; end
      end
      if (d0v && ($urandom % 2) == 0) begin
        busy = pick_reader(d0p);
        if (busy >= 0) begin d1v = 1; d1p = busy; end
      end
      irv = 0; irp = 0;
      if (retire_q.size() > 0 && ($urandom % 3) == 0) begin
        irv = 1; irp = retire_q.pop_front();
      end
      step("R3", iv, ihr, irs, irt, ird, d0v, d0p, d1v, d1p, irv, irp);
    end
    @(negedge clk);
    v = 0; dv = '0; rv = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule